// File: doc/BRIEF.md
# Constant-Injecting Final Adder for a Truncated-Multiplier FIR Filter

This block is the last stage of a sum-of-products filter datapath. The accumulated result arrives as a redundant pair of vectors (a sum row and a carry row). The block folds one precomputed constant into that pair, resolves the pair into a binary value, and registers the rounded high part as the filter output. The constant is worked out at elaboration time from the parameters. It gathers three terms: the two's-complement sign terms that every multiplication left out of its partial-product matrix, the bias correction for partial-product columns that the multipliers never formed, and the half-LSB that rounds the output.

The constant is injected by a row of cells and not by a row of full adders. In a column where the constant bit is 0, the cell is a plain half adder. In a column where the constant bit is 1, the cell adds its two inputs plus one. A ripple-carry adder then produces the binary result. This adder runs once per output sample, so the surrounding design may treat it as a multicycle path of up to TAPS/MULTS cycles.

Top module: `fir_const_final_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `y_out` is 0 after that edge.
- R2: The injected constant equals (SIGN + CORR + RND) modulo 2^DW, where DW = OUT_W + DROP_COLS + KEEP_COLS. SIGN = TAPS·(2^(A_W+B_W−1) + 2^(B_W−1) + 2^(A_W−1)). RND = 2^(DROP_COLS+KEEP_COLS−1), or 0 when both counts are 0.
- R3: CORR = round(TAPS·(DROP_COLS−1)/4 + TAPS/2^(DROP_COLS+2))·2^DROP_COLS, with halves rounded up. The rounding happens once, after scaling by TAPS, and not once per multiplication.
- R4: The constant-injection row outputs two rows whose sum modulo 2^DW equals acc_sum + acc_carry + constant. A column with constant bit 0 yields sum a XOR b and carry a AND b. A column with constant bit 1 yields sum a XNOR b and carry a OR b. Every carry moves one column up, and the carry out of the top column is dropped.
- R5: The carry-propagate adder outputs the binary sum of the two rows modulo 2^DW.
- R6: At a rising edge where `load_out` is 1, `y_out` takes bits [DW−1 : DROP_COLS+KEEP_COLS] of (acc_sum + acc_carry + constant) mod 2^DW.
- R7: At a rising edge where `load_out` is 0, `y_out` keeps its value, whatever `acc_sum` and `acc_carry` do.
- R8: Results that exceed 2^DW wrap, and the bits above DW−1 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sum | input | DW | Sum row of the accumulated result |
| acc_carry | input | DW | Carry row of the accumulated result |
| load_out | input | 1 | Capture the rounded result into the output register |
| y_out | output | OUT_W | Registered, rounded filter output |

## Verification
The bench sweeps every sum-row value of a 14-bit configuration against a scrambled carry row. It runs a second, 11-bit configuration with a different tap count and truncation depth at the same time, so both the constant bit pattern and the output alignment vary. A cell with the wrong polarity in a constant-1 column shows up as an off-by-2^i error that depends on the input pattern. A correction rounded per multiplication instead of after scaling shifts every output whose low bits sit near a rounding boundary; one directed input exposes this exactly. Wrapped sums with both rows near full scale catch a carry that is not dropped at the top. Hold cycles with changing inputs catch an output register that ignores its load enable.

// File: rtl/fir_fadd_pkg.sv
// Shared arithmetic for the final-addition stage.
// Assumes all widths stay below 63 bits so that 64-bit integer math is exact.
package fir_fadd_pkg;

    // Total constant added in the final stage, reduced modulo 2^dw.
    function automatic logic [63:0] fin_const(input int taps, input int aw, input int bw,
                                              input int drop, input int keep, input int dw);
        longint unsigned sign_t, corr_t, rnd_t, num, mask;
        sign_t = longint'(taps) * ((64'd1 << (aw + bw - 1)) + (64'd1 << (bw - 1)) + (64'd1 << (aw - 1)));
        if (drop > 0) begin
            // scaled average error, numerator over 2^(drop+2), rounded once
            num    = longint'(taps) * longint'(drop - 1) * (64'd1 << drop) + longint'(taps);
            corr_t = ((num + (64'd1 << (drop + 1))) >> (drop + 2)) << drop;
        end else begin
            corr_t = 64'd0;
        end
        rnd_t = (drop + keep > 0) ? (64'd1 << (drop + keep - 1)) : 64'd0;
        mask  = (64'd1 << dw) - 64'd1;
        return (sign_t + corr_t + rnd_t) & mask;
    endfunction

endpackage

// File: rtl/fadd_const_cell.sv
// One column of the constant-injection row.
// PLUS_ONE = 0: half adder. PLUS_ONE = 1: adds a + b + 1.
module fadd_const_cell #(
    parameter bit PLUS_ONE = 1'b0
) (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);
    generate
        if (PLUS_ONE) begin : g_plus1
            // a + b + 1 = 2*(a|b) + ~(a^b)
            assign s  = ~(a ^ b);
            assign co = a | b;
        end else begin : g_half
            // plain half adder
            assign s  = a ^ b;
            assign co = a & b;
        end
    endgenerate
endmodule

// File: rtl/fadd_const_csa.sv
// Row of constant-injection cells that reduces (a, b, CONST_VEC) to two rows.
// The carry out of the top column is dropped (modulo 2^DW).
module fadd_const_csa #(
    parameter int            DW        = 14,
    parameter logic [DW-1:0] CONST_VEC = '0
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] row_s,
    output logic [DW-1:0] row_c
);
    assign row_c[0] = 1'b0;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_col
            if (i < DW - 1) begin : g_full
                fadd_const_cell #(.PLUS_ONE(CONST_VEC[i])) i_cell (
                    .a (a[i]),
                    .b (b[i]),
                    .s (row_s[i]),
                    .co(row_c[i+1])
                );
            end else begin : g_top
                // top column: only the sum bit survives the modulus
                assign row_s[i] = CONST_VEC[i] ? ~(a[i] ^ b[i]) : (a[i] ^ b[i]);
            end
        end
    endgenerate
endmodule

// File: rtl/fadd_ripple_cpa.sv
// Ripple-carry adder, result modulo 2^DW; runs once per sample (multicycle).
module fadd_ripple_cpa #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] cy;
    assign cy[0] = 1'b0;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i] = x[i] ^ y[i] ^ cy[i];
            if (i < DW - 1) begin : g_carry
                // majority carry into the next bit
                assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
            end
        end
    endgenerate
endmodule

// File: rtl/fir_const_final_adder.sv
// Final-addition stage: injects the elaborated constant into a carry-save
// pair, resolves it with a ripple adder and registers the rounded output.
// Assumes the inputs stay stable for the multicycle window before load_out.
module fir_const_final_adder #(
    parameter int TAPS      = 4,
    parameter int A_W       = 6,
    parameter int B_W       = 6,
    parameter int DROP_COLS = 3,
    parameter int KEEP_COLS = 2,
    parameter int OUT_W     = 9,
    localparam int DW       = OUT_W + DROP_COLS + KEEP_COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    acc_sum,
    input  logic [DW-1:0]    acc_carry,
    input  logic             load_out,
    output logic [OUT_W-1:0] y_out
);
    import fir_fadd_pkg::*;

    localparam int          LSB    = DROP_COLS + KEEP_COLS;
    localparam logic [63:0] CTOTAL = fin_const(TAPS, A_W, B_W, DROP_COLS, KEEP_COLS, DW);

    logic [DW-1:0] scsa_s;
    logic [DW-1:0] scsa_c;
    logic [DW-1:0] cpa_sum;

    fadd_const_csa #(.DW(DW), .CONST_VEC(CTOTAL[DW-1:0])) i_csa (
        .a    (acc_sum),
        .b    (acc_carry),
        .row_s(scsa_s),
        .row_c(scsa_c)
    );

    fadd_ripple_cpa #(.DW(DW)) i_cpa (
        .x  (scsa_s),
        .y  (scsa_c),
        .sum(cpa_sum)
    );

    // output register: capture rounded high part on load, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)        y_out <= '0;
        else if (load_out) y_out <= cpa_sum[DW-1:LSB];
    end
endmodule

// File: rtl/fir_final_adder_chk.sv
// Assertion checker bound to fir_const_final_adder.
module fir_final_adder_chk #(
    parameter int TAPS      = 4,
    parameter int A_W       = 6,
    parameter int B_W       = 6,
    parameter int DROP_COLS = 3,
    parameter int KEEP_COLS = 2,
    parameter int OUT_W     = 9,
    localparam int DW       = OUT_W + DROP_COLS + KEEP_COLS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    acc_sum,
    input logic [DW-1:0]    acc_carry,
    input logic             load_out,
    input logic [OUT_W-1:0] y_out,
    input logic [DW-1:0]    row_s,
    input logic [DW-1:0]    row_c,
    input logic [DW-1:0]    cpa_out
);
    import fir_fadd_pkg::*;

    localparam int          LSB = DROP_COLS + KEEP_COLS;
    localparam logic [63:0] CT  = fin_const(TAPS, A_W, B_W, DROP_COLS, KEEP_COLS, DW);

    logic [DW-1:0] want_total;
    logic [DW-1:0] row_total;
    assign want_total = acc_sum + acc_carry + CT[DW-1:0];
    assign row_total  = row_s + row_c;

    assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> y_out == '0);

    assert_rows_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        row_total == want_total);

    assert_cpa_resolve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpa_out == row_total);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_out |=> y_out == $past(want_total[DW-1:LSB]));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_out |=> $stable(y_out));
endmodule

bind fir_const_final_adder fir_final_adder_chk #(
    .TAPS(TAPS), .A_W(A_W), .B_W(B_W),
    .DROP_COLS(DROP_COLS), .KEEP_COLS(KEEP_COLS), .OUT_W(OUT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_sum  (acc_sum),
    .acc_carry(acc_carry),
    .load_out (load_out),
    .y_out    (y_out),
    .row_s    (scsa_s),
    .row_c    (scsa_c),
    .cpa_out  (cpa_sum)
);

// File: tb/test_fir_const_final_adder.sv
// Bench: sweeps two configurations against arithmetic reference values.
module test_fir_const_final_adder;
    // config A: T=4, 6x6, drop 3, keep 2, out 9 -> DW 14
    // config B: T=3, 5x4, drop 2, keep 1, out 8 -> DW 11
    localparam int DWA = 14;
    localparam int DWB = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_out = 1'b0;
    logic [DWA-1:0] sa = '0, ca = '0;
    logic [DWB-1:0] sb = '0, cb = '0;
    logic [8:0] ya;
    logic [7:0] yb;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fir_const_final_adder #(.TAPS(4), .A_W(6), .B_W(6), .DROP_COLS(3), .KEEP_COLS(2), .OUT_W(9))
        i_fir_const_final_adder (.clk(clk), .rst_n(rst_n), .acc_sum(sa), .acc_carry(ca),
                                 .load_out(load_out), .y_out(ya));

    fir_const_final_adder #(.TAPS(3), .A_W(5), .B_W(4), .DROP_COLS(2), .KEEP_COLS(1), .OUT_W(8))
        i_fir_const_final_adder_b (.clk(clk), .rst_n(rst_n), .acc_sum(sb), .acc_carry(cb),
                                   .load_out(load_out), .y_out(yb));

    // reference constant from the stated formulas, using real arithmetic
    function automatic int ref_const(int t, int m, int n, int r, int k, int dw);
        int sign_t, corr_t, rnd_t;
        real x;
        sign_t = t * ((2 ** (m + n - 1)) + (2 ** (n - 1)) + (2 ** (m - 1)));
        x = t * (r - 1) / 4.0 + t / (2.0 ** (r + 2));
        corr_t = $rtoi($floor(x + 0.5)) * (2 ** r);
        rnd_t = (r + k > 0) ? 2 ** (r + k - 1) : 0;
        return (sign_t + corr_t + rnd_t) % (2 ** dw);
    endfunction

    function automatic int ref_y(int t, int m, int n, int r, int k, int dw, int s, int c);
        return ((s + c + ref_const(t, m, n, r, k, dw)) % (2 ** dw)) / (2 ** (r + k));
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive at negedge, one rising edge, sample at the following negedge
    task automatic apply(int s_a, int c_a, int s_b, int c_b, bit ld);
        @(negedge clk);
        sa = DWA'(s_a); ca = DWA'(c_a); sb = DWB'(s_b); cb = DWB'(c_b);
        load_out = ld;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int hold_a, hold_b;
        // R1: reset clears output even with load requested
        apply(16383, 16383, 2047, 2047, 1'b1);
        check("R1 reset A", int'(ya), 0);
        check("R1 reset B", int'(yb), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: zero inputs expose the constant itself (A: 8480 -> 265, B: 848 -> 106)
        apply(0, 0, 0, 0, 1'b1);
        check("R2 const A", int'(ya), 265);
        check("R2 const B", int'(yb), 106);

        // R3: rounding after scaling; per-multiplier rounding would give 266
        apply(16, 0, 3, 0, 1'b1);
        check("R3 corr A", int'(ya), 265);
        check("R3 corr B", int'(yb), 106);

        // R8: wrap past 2^DW
        apply(16383, 16383, 2047, 2047, 1'b1);
        check("R8 wrap A", int'(ya), ref_y(4, 6, 6, 3, 2, DWA, 16383, 16383));
        check("R8 wrap B", int'(yb), ref_y(3, 5, 4, 2, 1, DWB, 2047, 2047));

        // R4/R5/R6: sweep every sum-row value with a scrambled carry row
        for (int i = 0; i < 16384; i++) begin
            int a_c, b_s, b_c;
            a_c = (i * 40503 + 7) % 16384;
            b_s = i % 2048;
            b_c = (i * 613 + (i / 2048) * 97) % 2048;
            apply(i, a_c, b_s, b_c, 1'b1);
            check("R4 R5 R6 sweep A", int'(ya), ref_y(4, 6, 6, 3, 2, DWA, i, a_c));
            check("R4 R5 R6 sweep B", int'(yb), ref_y(3, 5, 4, 2, 1, DWB, b_s, b_c));
        end

        // R7: hold while inputs change and load is low
        apply(1234, 4321, 555, 777, 1'b1);
        hold_a = int'(ya);
        hold_b = int'(yb);
        for (int j = 0; j < 8; j++) begin
            apply(j * 1999, 16383 - j * 311, j * 201, 2047 - j * 55, 1'b0);
            check("R7 hold A", int'(ya), hold_a);
            check("R7 hold B", int'(yb), hold_b);
        end
        apply(100, 200, 300, 400, 1'b1);
        check("R6 reload A", int'(ya), ref_y(4, 6, 6, 3, 2, DWA, 100, 200));
        check("R6 reload B", int'(yb), ref_y(3, 5, 4, 2, 1, DWB, 300, 400));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule